// File: doc/BRIEF.md
# One-Hot Register Transaction Sequencer

This block is the secondary side of a register access path. A primary bus bridge presents a request together with a read/write flag, an address and a set of active-low space selects. The sequencer runs the transaction on a one-hot state machine and answers with an active-low acknowledge. The request and acknowledge follow a four-phase handshake: request low, acknowledge low, request high, acknowledge high. Between request and acknowledge the sequencer produces timed strobes and pulses for a bank of small registers.

A transaction starts when the request is low and at least one of the block's space selects is low. The sequencer then spends one cycle in a permit-decision state. If the permit qualifier is low, the transaction is bypassed and goes straight to the write-side acknowledge. A write passes through three execute cycles before it acknowledges. A read waits in a setup state until a collision-guard input reports that the buffer path is free, and only then acknowledges. The high address bits are compared with a base value and latched at the start of the transaction. A 4-to-16 decode of the low address bits then selects one operation. Each operation has a one-cycle write strobe, a write pulse, a read pulse and an 8-bit register. All pins are plain control or data levels that are qualified by the handshake. The block has no valid/ready stream and no back-pressure: the primary holds a request and its address and data stable until it sees the acknowledge, and the acknowledge waits for the request to be released.

Top module: `txn_slave_seq`

## Requirements
- R1: `state_oh` is one-hot at all times after reset. Its bit positions are 0 idle, 1 permit, 2 write-1, 3 write-2, 4 write-3, 5 write-ack, 6 read-setup and 7 read-ack. A synchronous `rst` puts the machine in idle.
- R2: The machine leaves idle only when `req_n`=0 and at least one bit of `space_sel_n` is 0, and it then goes only to permit.
- R3: From permit, `permit`=0 leads to write-ack, and that transaction changes no strobe, pulse or register. `permit`=1 with `wr_n`=0 leads to write-1, and `permit`=1 with `wr_n`=1 leads to read-setup.
- R4: write-1, write-2 and write-3 last one cycle each, in that order, and are followed by write-ack.
- R5: read-setup holds while `guard_ok`=0 and moves to read-ack in the cycle after `guard_ok`=1.
- R6: `ack_n` is 0 exactly in write-ack and read-ack. From either of these states the machine returns to idle in the cycle after it samples `req_n`=1.
- R7: `dout_en` is 1 exactly in read-setup and read-ack.
- R8: Operation i is selected when `addr[7:4]` matched `HI_BASE` (default 4'hA) at the idle-to-permit step and `addr[3:0]`=i. `rd_data` shows register i while `dout_en`=1 and operation i is selected, and is 0 otherwise.
- R9: `wr_strobe_n[i]` is 0 for exactly the write-2 cycle of a write to operation i, and 1 otherwise.
- R10: `wr_pulse_n[i]` goes 0 on entry to write-1 of a write to operation i and returns to 1 on entry to write-ack.
- R11: `rd_pulse_n[i]` goes 0 on entry to read-setup of a read from operation i and returns to 1 on re-entry to idle.
- R12: Register i, at bits `[8i+7:8i]` of `reg_file_q`, loads `wdata` on entry to write-2 of a write to operation i. Reset sets every register to `REG_INIT` (default 8'h5A).
- R13: `nxt_oh` is the one-hot state, with the bit positions of R1, that the machine will take at the next clock edge given the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Transaction request, active low |
| wr_n | input | 1 | 0 = write, 1 = read |
| space_sel_n | input | NSPACE | Active-low space selects served by this block |
| addr | input | AW | Transaction address |
| wdata | input | DW | Write data |
| permit | input | 1 | 1 = execute the transaction, 0 = bypass it |
| guard_ok | input | 1 | 1 = buffer path free, read may complete |
| ack_n | output | 1 | Acknowledge, active low |
| dout_en | output | 1 | Read data bus drive enable |
| rd_data | output | DW | Read data of the selected register |
| state_oh | output | 8 | Present one-hot state |
| nxt_oh | output | 8 | Next one-hot state |
| wr_strobe_n | output | NOPS | One-cycle write strobes, active low |
| wr_pulse_n | output | NOPS | Write pulses, active low |
| rd_pulse_n | output | NOPS | Read pulses, active low |
| reg_file_q | output | NOPS*DW | Contents of all operation registers |

## Verification
The hardest case to reach is a read that stalls in read-setup while `guard_ok` stays low for several cycles, with its read pulse and data drive held the whole time. The stimulus holds `guard_ok` low for a chosen number of cycles within each read. Other stimulus also checks the edges of the handshake. The request is kept low for many cycles after the acknowledge. A request arrives with no space select low. A permit-low write is sent that must leave the registers alone. A high address misses the base. A reset is applied in the middle of a write. On every clock, every output is compared with a behavioural model.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;
  localparam int NSTATES = 8;
  typedef enum int unsigned {
    S_IDLE = 0,
    S_PERM = 1,
    S_W1   = 2,
    S_W2   = 3,
    S_W3   = 4,
    S_WACK = 5,
    S_RSET = 6,
    S_RACK = 7
  } st_idx_e;
endpackage

// File: rtl/txn_fsm.sv
module txn_fsm
  import txn_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_n,
  input  logic               access,
  input  logic               permit,
  input  logic               wr_n,
  input  logic               guard_ok,
  output logic [NSTATES-1:0] state_q,
  output logic [NSTATES-1:0] nxt
);
  always_comb begin
    nxt = '0;
    nxt[S_IDLE] = ((state_q[S_WACK] | state_q[S_RACK]) & req_n)
                | (state_q[S_IDLE] & (req_n | ~access));
    nxt[S_PERM] = state_q[S_IDLE] & ~req_n & access;
    nxt[S_W1]   = state_q[S_PERM] & permit & ~wr_n;
    nxt[S_W2]   = state_q[S_W1];
    nxt[S_W3]   = state_q[S_W2];
    nxt[S_WACK] = state_q[S_W3] | (state_q[S_WACK] & ~req_n)
                | (state_q[S_PERM] & ~permit);
    nxt[S_RSET] = (state_q[S_PERM] & permit & wr_n)
                | (state_q[S_RSET] & ~guard_ok);
    nxt[S_RACK] = (state_q[S_RSET] & guard_ok) | (state_q[S_RACK] & ~req_n);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= NSTATES'(1);
    else     state_q <= nxt;
  end

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[S_IDLE] && (req_n || !access) |=> state_q[S_IDLE]);
  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[S_PERM] && !permit |=> state_q[S_WACK]);
  // R4
  w1_w2_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[S_W1] |=> state_q[S_W2]);
  // R4
  w3_wack_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[S_W3] |=> state_q[S_WACK]);
  // R5
  guard_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[S_RSET] && !guard_ok |=> state_q[S_RSET]);
endmodule

// File: rtl/txn_decode.sv
module txn_decode #(
  parameter int AW = 8,
  parameter int LB = 4,
  parameter logic [AW-LB-1:0] HI_BASE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_txn,
  input  logic [AW-1:0]      addr,
  output logic [(1<<LB)-1:0] op_sel
);
  localparam int NOPS = 1 << LB;

  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst)           hit_q <= 1'b0;
    else if (take_txn) hit_q <= (addr[AW-1:LB] == HI_BASE);
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_dec
    assign op_sel[g] = hit_q && (addr[LB-1:0] == LB'(g));
  end
endmodule

// File: rtl/txn_ops.sv
module txn_ops
  import txn_seq_pkg::*;
#(
  parameter int NOPS = 16,
  parameter int DW = 8,
  parameter logic [DW-1:0] REG_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSTATES-1:0] nxt,
  input  logic [NOPS-1:0]    op_sel,
  input  logic [DW-1:0]      wdata,
  output logic [NOPS-1:0]    wr_strobe_n,
  output logic [NOPS-1:0]    wr_pulse_n,
  output logic [NOPS-1:0]    rd_pulse_n,
  output logic [NOPS*DW-1:0] reg_file_q
);
  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic hit_w1, hit_w2, hit_rs;
    assign hit_w1 = op_sel[g] & nxt[S_W1];
    assign hit_w2 = op_sel[g] & nxt[S_W2];
    assign hit_rs = op_sel[g] & nxt[S_RSET];

    always_ff @(posedge clk) begin
      if (rst) begin
        wr_strobe_n[g] <= 1'b1;
        wr_pulse_n[g]  <= 1'b1;
        rd_pulse_n[g]  <= 1'b1;
        reg_file_q[g*DW +: DW] <= REG_INIT;
      end else begin
        wr_strobe_n[g] <= ~hit_w2;
        if (hit_w1 | nxt[S_WACK]) wr_pulse_n[g] <= ~hit_w1;
        if (hit_rs | nxt[S_IDLE]) rd_pulse_n[g] <= ~hit_rs;
        if (hit_w2) reg_file_q[g*DW +: DW] <= wdata;
      end
    end

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_strobe_n[g] |=> wr_strobe_n[g]);
  end
endmodule

// File: rtl/txn_slave_seq.sv
module txn_slave_seq
  import txn_seq_pkg::*;
#(
  parameter int NSPACE = 2,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int LB = 4,
  parameter logic [AW-LB-1:0] HI_BASE = 4'hA,
  parameter logic [DW-1:0] REG_INIT = 8'h5A,
  localparam int NOPS = 1 << LB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_n,
  input  logic               wr_n,
  input  logic [NSPACE-1:0]  space_sel_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               permit,
  input  logic               guard_ok,
  output logic               ack_n,
  output logic               dout_en,
  output logic [DW-1:0]      rd_data,
  output logic [NSTATES-1:0] state_oh,
  output logic [NSTATES-1:0] nxt_oh,
  output logic [NOPS-1:0]    wr_strobe_n,
  output logic [NOPS-1:0]    wr_pulse_n,
  output logic [NOPS-1:0]    rd_pulse_n,
  output logic [NOPS*DW-1:0] reg_file_q
);
  logic access;
  logic [NOPS-1:0] op_sel;

  assign access = ~&space_sel_n;

  txn_fsm u_fsm (
    .clk(clk), .rst(rst), .req_n(req_n), .access(access), .permit(permit),
    .wr_n(wr_n), .guard_ok(guard_ok), .state_q(state_oh), .nxt(nxt_oh)
  );

  txn_decode #(.AW(AW), .LB(LB), .HI_BASE(HI_BASE)) u_dec (
    .clk(clk), .rst(rst), .take_txn(state_oh[S_IDLE] & nxt_oh[S_PERM]),
    .addr(addr), .op_sel(op_sel)
  );

  txn_ops #(.NOPS(NOPS), .DW(DW), .REG_INIT(REG_INIT)) u_ops (
    .clk(clk), .rst(rst), .nxt(nxt_oh), .op_sel(op_sel), .wdata(wdata),
    .wr_strobe_n(wr_strobe_n), .wr_pulse_n(wr_pulse_n),
    .rd_pulse_n(rd_pulse_n), .reg_file_q(reg_file_q)
  );

  assign ack_n   = ~(state_oh[S_WACK] | state_oh[S_RACK]);
  assign dout_en = state_oh[S_RSET] | state_oh[S_RACK];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NOPS; i++)
      if (dout_en && op_sel[i]) rd_data = reg_file_q[i*DW +: DW];
  end

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n && !req_n |=> !ack_n);
  // R9
  strobe_in_w2_chk: assert property (@(posedge clk) disable iff (rst)
    !(&wr_strobe_n) |-> state_oh[S_W2]);
  // R10
  wpulse_window_chk: assert property (@(posedge clk) disable iff (rst)
    !(&wr_pulse_n) |-> (state_oh[S_W1] | state_oh[S_W2] | state_oh[S_W3]));
  // R11
  rpulse_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !(&rd_pulse_n) |-> dout_en);
endmodule

// File: tb/txn_slave_seq_tb_top.sv
module txn_slave_seq_tb_top;
  localparam int CLK_PERIOD = 100;

  logic clk = 0;
  logic rst = 1;
  logic req_n = 1, wr_n = 1, permit = 0, guard_ok = 0;
  logic [1:0] space_sel_n = 2'b11;
  logic [7:0] addr = 0, wdata = 0;
  logic ack_n, dout_en;
  logic [7:0] rd_data, state_oh, nxt_oh;
  logic [15:0] wr_strobe_n, wr_pulse_n, rd_pulse_n;
  logic [127:0] reg_file_q;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_slave_seq dut_i (
    .clk(clk), .rst(rst), .req_n(req_n), .wr_n(wr_n), .space_sel_n(space_sel_n),
    .addr(addr), .wdata(wdata), .permit(permit), .guard_ok(guard_ok),
    .ack_n(ack_n), .dout_en(dout_en), .rd_data(rd_data), .state_oh(state_oh),
    .nxt_oh(nxt_oh), .wr_strobe_n(wr_strobe_n), .wr_pulse_n(wr_pulse_n),
    .rd_pulse_n(rd_pulse_n), .reg_file_q(reg_file_q)
  );

  // behavioural model: state numbers 0 idle .. 7 read-ack
  int m_state = 0;
  bit m_hit = 0;
  logic [15:0] m_ws = '1, m_wp = '1, m_rp = '1;
  logic [7:0] m_reg [16];

  function automatic int next_of(int s);
    bit acc = (space_sel_n != 2'b11);
    case (s)
      0: return (!req_n && acc) ? 1 : 0;
      1: return !permit ? 5 : (!wr_n ? 2 : 6);
      2: return 3;
      3: return 4;
      4: return 5;
      5: return req_n ? 0 : 5;
      6: return guard_ok ? 7 : 6;
      default: return req_n ? 0 : 7;
    endcase
  endfunction

  always @(posedge clk) begin
    int nx, sel;
    cycles++;
    if (rst) begin
      m_state = 0; m_hit = 0; m_ws = '1; m_wp = '1; m_rp = '1;
      for (int i = 0; i < 16; i++) m_reg[i] = 8'h5A;
    end else begin
      nx = next_of(m_state);
      sel = m_hit ? int'(addr[3:0]) : -1;
      m_ws = '1;
      if (nx == 3 && sel >= 0) begin m_ws[sel] = 1'b0; m_reg[sel] = wdata; end
      if (nx == 2 && sel >= 0) m_wp[sel] = 1'b0;
      if (nx == 5) m_wp = '1;
      if (nx == 6 && sel >= 0) m_rp[sel] = 1'b0;
      if (nx == 0) m_rp = '1;
      if (m_state == 0 && nx == 1) m_hit = (addr[7:4] == 4'hA);
      m_state = nx;
    end
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [127:0] er;
    logic [7:0] erd;
    @(negedge clk);
    #1;
    for (int i = 0; i < 16; i++) er[i*8 +: 8] = m_reg[i];
    erd = ((m_state == 6 || m_state == 7) && m_hit) ? m_reg[addr[3:0]] : 8'h00;
    chk("R1/R2/R3/R4/R5 state", 128'(state_oh), 128'(8'(1) << m_state));
    chk("R13 nxt_oh", 128'(nxt_oh), 128'(8'(1) << next_of(m_state)));
    chk("R6 ack_n", 128'(ack_n), 128'(!(m_state == 5 || m_state == 7)));
    chk("R7 dout_en", 128'(dout_en), 128'(m_state == 6 || m_state == 7));
    chk("R8 rd_data", 128'(rd_data), 128'(erd));
    chk("R9 wr_strobe_n", 128'(wr_strobe_n), 128'(m_ws));
    chk("R10 wr_pulse_n", 128'(wr_pulse_n), 128'(m_wp));
    chk("R11 rd_pulse_n", 128'(rd_pulse_n), 128'(m_rp));
    chk("R12 reg_file_q", reg_file_q, er);
  endtask

  task automatic txn(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     input bit perm, input logic [1:0] sel, input int gdelay,
                     input int hold);
    req_n = 0; wr_n = !wr; addr = a; wdata = d; permit = perm;
    space_sel_n = sel; guard_ok = (gdelay == 0);
    for (int n = 0; n < 30; n++) begin
      tick();
      if (n + 1 >= gdelay) guard_ok = 1;
      if (m_state == 5 || m_state == 7) break;
    end
    repeat (hold) tick();
    req_n = 1; space_sel_n = 2'b11;
    tick(); tick();
    guard_ok = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    tick();                                  // R1 reset state
    txn(1, 8'hA3, 8'h3C, 1, 2'b10, 0, 0);    // R4 R9 R10 R12 write op 3
    txn(0, 8'hA3, 8'h00, 1, 2'b01, 0, 1);    // R5 R8 R11 read op 3 at once
    txn(0, 8'hA3, 8'h00, 1, 2'b10, 4, 0);    // R5 read stalled by guard
    txn(1, 8'hA7, 8'hE1, 0, 2'b00, 0, 2);    // R3 bypass, register unchanged
    txn(0, 8'hA7, 8'h00, 1, 2'b10, 1, 0);    // R3 read back op 7 = init
    txn(1, 8'h53, 8'h99, 1, 2'b10, 0, 0);    // R8 high address miss
    txn(0, 8'h53, 8'h00, 1, 2'b10, 0, 0);    // R8 miss reads zero
    txn(1, 8'hA3, 8'h77, 1, 2'b11, 0, 0);    // R2 no space select, stays idle
    txn(1, 8'hAF, 8'hF0, 1, 2'b01, 0, 6);    // R6 long request hold
    txn(1, 8'hA0, 8'h01, 1, 2'b10, 0, 0);    // R12 op 0
    txn(0, 8'hAF, 8'h00, 1, 2'b10, 2, 3);    // R11 read op 15
    txn(0, 8'hA0, 8'h00, 1, 2'b10, 0, 0);
    // R1 reset in the middle of a write
    req_n = 0; wr_n = 0; addr = 8'hA5; wdata = 8'h12; permit = 1; space_sel_n = 2'b10;
    tick(); tick(); tick();
    rst = 1; req_n = 1; space_sel_n = 2'b11;
    tick();
    rst = 0;
    tick(); tick();
    txn(0, 8'hA3, 8'h00, 1, 2'b10, 0, 0);    // R12 reset restored init
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule